// File: doc/BRIEF.md
# Counter-Timer Bus Write Front End

This block is the write side of the processor-bus interface of a four-channel counter/timer. The bus has no write strobe. The block recognises a write from the I/O request, chip enable, read and first-machine-cycle pins. The bus clock is also the block clock. On the first rising edge at which I/O request is seen low, the block takes the data byte and the two-bit channel number straight from the pins.

The byte is steered to the addressed channel. It becomes one of three things:

- A control word, when data bit 0 is 1.
- An interrupt vector, when data bit 0 is 0. This is accepted on channel 0 only.
- A time constant, when the channel's previous control word asked for one.

The block holds every channel's control and time-constant registers and the single vector register. For each accepted write it gives a one-clock load pulse on the target channel, together with a code that says what kind of word was loaded. The counting engines use these outputs.

Top module: `ctr_wr_front`

## Requirements
- R1: A synchronous active-high reset clears every control, time-constant and vector register to 0. It also clears all pending time-constant flags, and it holds `load_o` at 0 and `load_kind_o` at 00.
- R2: A write is accepted only at a rising edge where all of these hold:
  - `iorq_n` is sampled low, and it was sampled high at the previous edge. After reset it must first be sampled high.
  - `ce_n` is low.
  - `rd_n` is high.
  - `m1_n` is high.
  
  A cycle with `rd_n` low or `ce_n` high changes nothing and gives no pulse.
- R3: When `m1_n` is low, the cycle is an interrupt acknowledge. Nothing is written and `load_o` stays 0 in the next cycle.
- R4: `din` and `cs` are taken from the pins at the accepting edge. The new register value and the load pulse are visible in the clock cycle after that edge.
- R5: `cs` selects the channel. Only bit `cs` of `load_o` pulses, and only that channel's registers change.
- R6: With no time constant pending on the channel, a byte with bit 0 = 1 is stored in that channel's control register, and `load_kind_o` = 01.
- R7: A stored control word with bit 2 = 1 marks its channel as pending. The next accepted write to that channel is stored in its time-constant register whatever its bit 0 is, `load_kind_o` = 11, and the flag is cleared. Writes to other channels do not touch the flag.
- R8: With nothing pending, a byte with bit 0 = 0 on channel 0 is stored in `vec_o`, and `load_kind_o` = 10 with `load_o[0]` set. The same byte on any other channel is ignored: no register changes and no pulse.
- R9: A time constant of 0 is stored as 0. The counting engine reads it as 256.
- R10: Each accepted write gives exactly one single-clock pulse, even when the strobes stay low for several clocks.
- R11: `load_o` has at most one bit set. `load_kind_o` is 00 whenever `load_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read, active low; high qualifies a write |
| m1_n | input | 1 | First machine cycle, active low; low marks an interrupt acknowledge |
| cs | input | 2 | Channel select |
| din | input | 8 | Data bus |
| ctrl_o | output | 32 | Control registers, channel n in bits 8n+7:8n |
| tc_o | output | 32 | Time-constant registers, channel n in bits 8n+7:8n |
| vec_o | output | 8 | Interrupt vector register |
| load_o | output | 4 | One-clock load pulse per channel |
| load_kind_o | output | 2 | Kind of the pulsed load: 00 none, 01 control, 10 vector, 11 time constant |

## Verification
A wrong pending flag has no effect until the next write to its channel. That write then shows at the ports as the wrong load kind and a change to the wrong register, one cycle after its accepting edge. For this reason the bench writes to other channels between setting a flag and using it, and it applies a reset while a flag is pending.

A stale I/O-request history shows up within a single clock, as a second pulse while the strobes are held low. Every write is followed by a full comparison of all registers, so a write that lands in the wrong place is caught before the next bus cycle starts.

// File: rtl/ctw_pkg.sv
package ctw_pkg;
  typedef enum logic [1:0] {
    LD_NONE = 2'b00,
    LD_CTRL = 2'b01,
    LD_VEC  = 2'b10,
    LD_TC   = 2'b11
  } ld_kind_e;
endpackage

// File: rtl/ctw_cycle_detect.sv
// Infers a write from the bus strobes; fires on the first edge that sees
// I/O request low after having seen it high.
module ctw_cycle_detect (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic iorq_n,
  input  logic rd_n,
  input  logic m1_n,
  output logic accept_o
);
  logic iorq_hi_q;

  always_ff @(posedge clk) begin
    if (rst) iorq_hi_q <= 1'b0;
    else     iorq_hi_q <= iorq_n;
  end

  assign accept_o = iorq_hi_q & ~iorq_n & ~ce_n & rd_n & m1_n;
endmodule

// File: rtl/ctw_word_steer.sv
// Classifies the captured byte and selects the target channel.
module ctw_word_steer
  import ctw_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int DW       = 8,
  parameter int CTRL_BIT = 0,
  parameter int VEC_CH   = 0,
  localparam int CSW     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           accept_i,
  input  logic [CSW-1:0] cs_i,
  input  logic [DW-1:0]  din_i,
  input  logic [NCH-1:0] pend_i,
  output ld_kind_e       kind_o,
  output logic [NCH-1:0] hit_o
);
  always_comb begin
    kind_o = LD_NONE;
    if (accept_i) begin
      if (pend_i[cs_i])                 kind_o = LD_TC;
      else if (din_i[CTRL_BIT])         kind_o = LD_CTRL;
      else if (cs_i == CSW'(VEC_CH))    kind_o = LD_VEC;
      else                              kind_o = LD_NONE;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_hit
    assign hit_o[i] = (kind_o != LD_NONE) && (cs_i == CSW'(i));
  end
endmodule

// File: rtl/ctw_chan_slot.sv
// Per-channel control, time constant, pending flag and load pulse.
module ctw_chan_slot
  import ctw_pkg::*;
#(
  parameter int DW      = 8,
  parameter int TCF_BIT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit_i,
  input  ld_kind_e      kind_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] tc_q,
  output logic          pend_q,
  output logic          load_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      tc_q   <= '0;
      pend_q <= 1'b0;
      load_q <= 1'b0;
    end else begin
      load_q <= hit_i;
      if (hit_i) begin
        case (kind_i)
          LD_CTRL: begin
            ctrl_q <= din_i;
            pend_q <= din_i[TCF_BIT];
          end
          LD_TC: begin
            tc_q   <= din_i;
            pend_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_i && pend_q) |=> !pend_q);

  // R6
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !hit_i |=> $stable(ctrl_q));

  // R5
  tc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !hit_i |=> $stable(tc_q));
endmodule

// File: rtl/ctr_wr_front.sv
module ctr_wr_front
  import ctw_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int DW       = 8,
  parameter int CTRL_BIT = 0,
  parameter int TCF_BIT  = 2,
  parameter int VEC_CH   = 0,
  localparam int CSW     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              m1_n,
  input  logic [CSW-1:0]    cs,
  input  logic [DW-1:0]     din,
  output logic [NCH*DW-1:0] ctrl_o,
  output logic [NCH*DW-1:0] tc_o,
  output logic [DW-1:0]     vec_o,
  output logic [NCH-1:0]    load_o,
  output logic [1:0]        load_kind_o
);
  logic           accept;
  ld_kind_e       kind;
  ld_kind_e       kind_q;
  logic [NCH-1:0] hit;
  logic [NCH-1:0] pend;

  ctw_cycle_detect u_detect (
    .clk(clk), .rst(rst), .ce_n(ce_n), .iorq_n(iorq_n),
    .rd_n(rd_n), .m1_n(m1_n), .accept_o(accept)
  );

  ctw_word_steer #(
    .NCH(NCH), .DW(DW), .CTRL_BIT(CTRL_BIT), .VEC_CH(VEC_CH)
  ) u_steer (
    .accept_i(accept), .cs_i(cs), .din_i(din), .pend_i(pend),
    .kind_o(kind), .hit_o(hit)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    ctw_chan_slot #(.DW(DW), .TCF_BIT(TCF_BIT)) u_slot (
      .clk(clk), .rst(rst), .hit_i(hit[i]), .kind_i(kind), .din_i(din),
      .ctrl_q(ctrl_o[i*DW +: DW]), .tc_q(tc_o[i*DW +: DW]),
      .pend_q(pend[i]), .load_q(load_o[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_o  <= '0;
      kind_q <= LD_NONE;
    end else begin
      kind_q <= (|hit) ? kind : LD_NONE;
      if (kind == LD_VEC) vec_o <= din;
    end
  end

  assign load_kind_o = kind_q;

  // R3
  inta_no_load_chk: assert property (@(posedge clk) disable iff (rst)
    !m1_n |=> load_o == '0);

  // R11
  load_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(load_o));

  // R11
  kind_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (load_o == '0) |-> (load_kind_o == LD_NONE));

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (|load_o) |=> (load_o == '0));

  // R8
  vec_chan_chk: assert property (@(posedge clk) disable iff (rst)
    (load_kind_o == LD_VEC) |-> load_o[VEC_CH]);

  // R2
  read_no_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || ce_n) |=> (load_o == '0));
endmodule

// File: tb/tb_ctr_wr_front.sv
module tb_ctr_wr_front;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0] ch;
    logic [1:0] kind;
    logic [7:0] data;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, m1_n = 1'b1;
  logic [1:0]  cs = '0;
  logic [7:0]  din = '0;
  logic [31:0] ctrl_o, tc_o;
  logic [7:0]  vec_o;
  logic [3:0]  load_o;
  logic [1:0]  load_kind_o;

  int total = 0;
  int bad = 0;
  exp_t q[$];

  logic [7:0] m_ctrl [4];
  logic [7:0] m_tc [4];
  logic       m_pend [4];
  logic [7:0] m_vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctr_wr_front dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .iorq_n(iorq_n), .rd_n(rd_n),
    .m1_n(m1_n), .cs(cs), .din(din), .ctrl_o(ctrl_o), .tc_o(tc_o),
    .vec_o(vec_o), .load_o(load_o), .load_kind_o(load_kind_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin
      m_ctrl[i] = '0; m_tc[i] = '0; m_pend[i] = 1'b0;
    end
    m_vec = '0;
  endtask

  task automatic check_all(input string req);
    logic [31:0] ec, et;
    for (int i = 0; i < 4; i++) begin
      ec[i*8 +: 8] = m_ctrl[i];
      et[i*8 +: 8] = m_tc[i];
    end
    chk(ctrl_o == ec, req, "ctrl regs", ctrl_o, ec);
    chk(tc_o == et, req, "tc regs", tc_o, et);
    chk(vec_o == m_vec, req, "vector", {24'b0, vec_o}, {24'b0, m_vec});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; iorq_n = 1'b1; ce_n = 1'b1; rd_n = 1'b1; m1_n = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
    q.delete();
  endtask

  // driver: one bus cycle T1, T2, then strobes held for 'hold' clocks
  task automatic bus_write(input logic [1:0] ch, input logic [7:0] d,
                           input logic m1, input logic rd, input logic ce,
                           input int hold, input string req);
    exp_t e;
    bit   fire = 1'b0;
    e.ch = ch; e.data = d; e.kind = 2'b00;
    if (m1 && rd && !ce) begin
      if (m_pend[ch]) begin
        e.kind = 2'b11; m_tc[ch] = d; m_pend[ch] = 1'b0; fire = 1'b1;
      end else if (d[0]) begin
        e.kind = 2'b01; m_ctrl[ch] = d; m_pend[ch] = d[2]; fire = 1'b1;
      end else if (ch == 2'd0) begin
        e.kind = 2'b10; m_vec = d; fire = 1'b1;
      end
    end
    if (fire) q.push_back(e);
    @(negedge clk);                       // T1
    iorq_n = 1'b1; ce_n = 1'b1; rd_n = rd; m1_n = m1;
    @(negedge clk);                       // T2
    iorq_n = 1'b0; ce_n = ce; cs = ch; din = d;
    @(negedge clk);                       // after edge starting T3
    // R4: pulse visible in the cycle right after the capturing edge
    if (fire) chk(load_o == (4'b1 << ch), "R4", "pulse timing", {28'b0, load_o}, {28'b0, 4'b1 << ch});
    else      chk(load_o == 4'b0, req, "no pulse", {28'b0, load_o}, 32'b0);
    repeat (hold - 1) @(negedge clk);
    iorq_n = 1'b1; ce_n = 1'b1; rd_n = 1'b1; m1_n = 1'b1; din = 8'hxx;
    @(negedge clk);
    chk(q.size() == 0, req, "missing pulse", q.size(), 0);
    check_all(req);
  endtask

  // monitor: pop expected loads as pulses appear
  always @(negedge clk) begin
    if (!rst && (load_o != 4'b0)) begin
      if (q.size() == 0) begin
        chk(1'b0, "R10", "unexpected pulse", {28'b0, load_o}, 32'b0);
      end else begin
        exp_t e;
        logic [7:0] got;
        e = q.pop_front();
        // R5 channel select
        chk(load_o == (4'b1 << e.ch), "R5", "pulse channel", {28'b0, load_o}, {28'b0, 4'b1 << e.ch});
        chk(load_kind_o == e.kind, "R11", "load kind", {30'b0, load_kind_o}, {30'b0, e.kind});
        case (e.kind)
          2'b01:   got = ctrl_o[e.ch*8 +: 8];
          2'b11:   got = tc_o[e.ch*8 +: 8];
          default: got = vec_o;
        endcase
        chk(got == e.data, "R6", "loaded value", {24'b0, got}, {24'b0, e.data});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_clear();
    do_reset();
    @(negedge clk);
    // R1 reset state
    check_all("R1");
    chk(load_o == 4'b0, "R1", "load after reset", {28'b0, load_o}, 32'b0);
    chk(load_kind_o == 2'b0, "R1", "kind after reset", {30'b0, load_kind_o}, 32'b0);

    bus_write(2'd1, 8'h41, 1, 1, 0, 1, "R6");   // R6 control word
    bus_write(2'd0, 8'hA8, 1, 1, 0, 1, "R8");   // R8 vector on channel 0
    bus_write(2'd2, 8'h50, 1, 1, 0, 1, "R8");   // R8 vector on channel 2 ignored
    bus_write(2'd2, 8'h85, 1, 1, 0, 1, "R7");   // R7 time constant follows
    bus_write(2'd3, 8'h11, 1, 1, 0, 1, "R7");   // other channel, flag kept
    bus_write(2'd2, 8'h00, 1, 1, 0, 1, "R9");   // R9 tc of zero stored as 0
    bus_write(2'd2, 8'h60, 1, 1, 0, 1, "R7");   // flag cleared: ignored vector
    bus_write(2'd0, 8'h07, 1, 1, 0, 1, "R7");
    bus_write(2'd0, 8'h01, 1, 1, 0, 1, "R7");   // taken as tc despite bit0=1
    bus_write(2'd1, 8'h33, 0, 1, 0, 1, "R3");   // R3 interrupt acknowledge
    bus_write(2'd1, 8'h35, 1, 0, 0, 1, "R2");   // R2 read cycle
    bus_write(2'd1, 8'h37, 1, 1, 1, 1, "R2");   // R2 chip not enabled
    bus_write(2'd3, 8'hC3, 1, 1, 0, 6, "R10");  // R10 held strobes
    for (int i = 0; i < 4; i++) begin
      bus_write(2'(i), 8'(8'h21 + 8'(i * 16)), 1, 1, 0, 2, "R5");
    end
    // R1 reset clears a pending flag
    bus_write(2'd3, 8'h0D, 1, 1, 0, 1, "R1");
    do_reset();
    @(negedge clk);
    check_all("R1");
    bus_write(2'd3, 8'h03, 1, 1, 0, 1, "R1");

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule